// File: doc/BRIEF.md
# Four-Space Asynchronous Static Bus Controller

This block connects an internal port that issues one 32-bit request at a time to an external asynchronous static bus. SRAM, ROM, EPROM or Flash devices and memory-mapped I/O registers can all sit on that bus. The two top bits of the 24-bit internal byte address pick one of four spaces. Each space has its own active-low chip select. The low 22 bits address up to 4 MB inside the chosen space.

Each space has its own bus width (8, 16 or 32 bits) and its own wait-state count, held in a small configuration bank. After reset every space is set to 8 bits with the largest wait-state count, so that a slow boot ROM can be read before software tunes the timing. A request to a narrow space is split into two or four beats. Read beats are packed into one 32-bit word and write words are split into lanes. The requester sees one access and one completion pulse, whatever the width.

Top module: `xbus_ctrl`

## Requirements
- R1: `req_addr[23:22]` selects the space. During a request only `ext_cs_n[space]` is low, and it stays low without a break from the first setup cycle to the last hold cycle. All chip selects are high in every other cycle.
- R2: Width code 0 means an 8-bit space with 4 beats, code 1 a 16-bit space with 2 beats, and codes 2 and 3 a 32-bit space with 1 beat. The beat address starts at `req_addr[21:0]` with bits 1:0 forced to zero and rises by the beat's byte count for each later beat.
- R3: A space programmed with wait count W holds its strobe low for exactly W+1 cycles on every beat. W is 4 bits wide.
- R4: Each beat has one setup cycle with chip select low and both strobes high, then the strobe cycles, then one hold cycle with chip select low and both strobes high.
- R5: Reads drive `ext_oe_n` low. Data is sampled from the low lanes of `ext_dq_i` on the last strobe cycle and assembled little-endian, with the lowest address in the least significant byte.
- R6: Writes drive `ext_we_n` low and never `ext_oe_n`. Beat k puts bytes k*B to k*B+B-1 of the write word on `ext_dq_o[8B-1:0]`, where B is the beat's byte count. `ext_dq_oe` is high exactly when `ext_we_n` is low.
- R7: `rsp_done` is a one-cycle pulse in the cycle after the last hold cycle. With acceptance at clock edge 0, it is high after edge beats*(W+3). `rsp_rdata` holds the assembled read word from that pulse until the next request is accepted.
- R8: A request is accepted only when `busy` is low. A `req_valid` seen while `busy` is high is ignored and starts no bus activity.
- R9: During reset all chip selects and strobes are high, `ext_dq_oe`, `busy` and `rsp_done` are low, and every space returns to width code 0 with wait count 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Space whose configuration is written |
| cfg_width | input | 2 | Width code to store (0: 8-bit, 1: 16-bit, 2/3: 32-bit) |
| cfg_wait | input | 4 | Wait-state count to store |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 24 | Byte address; bits 23:22 pick the space |
| req_wdata | input | 32 | Write word |
| busy | output | 1 | A request is in progress |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Assembled read word |
| ext_addr | output | 22 | External byte address |
| ext_cs_n | output | 4 | Per-space chip selects, active low |
| ext_we_n | output | 1 | Write strobe, active low |
| ext_oe_n | output | 1 | Output enable strobe, active low |
| ext_dq_o | output | 32 | Data driven to the bus |
| ext_dq_oe | output | 1 | Drive enable for `ext_dq_o` |
| ext_dq_i | input | 32 | Data read from the bus |

## Verification
The checker watches the bus rules on every cycle: at most one chip select low, never both strobes low, chip select already low before a strobe falls and still low after it rises, data driven only under the write strobe, strobe runs no longer than the largest wait count, and a stable chip select for the whole request. It also checks that an accepted request raises `busy` and that the completion pulse lasts one cycle. The bench's sweeps over every space, width code and several wait counts are needed to show the exact beat count, per-beat addresses, strobe length, latency and little-endian packing and splitting. Only the bench can also show that a request held during a busy access leaves both the bus and memory untouched.

// File: rtl/xbus_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the static bus controller.
// Assumes a 32-bit internal word; width codes: 0 = 8-bit, 1 = 16-bit, 2/3 = 32-bit.
package xbus_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_t;

    // Number of bus beats minus one for a width code.
    function automatic logic [1:0] beats_less_one(input logic [1:0] code);
        case (code)
            2'd0:    return 2'd3;
            2'd1:    return 2'd1;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/xbus_cfg_bank.sv
`timescale 1ns/1ps
// Per-space configuration bank: one width code and one wait count per space.
// Assumes writes come from a single configuration port; reads are combinational
// so the top can latch the selected space's settings in the accept cycle.
module xbus_cfg_bank #(
    parameter int SPACE_W = 2,
    parameter int WAIT_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [SPACE_W-1:0] cfg_sel,
    input  logic [1:0]         cfg_width,
    input  logic [WAIT_W-1:0]  cfg_wait,
    input  logic [SPACE_W-1:0] rd_sel,
    output logic [1:0]         rd_width,
    output logic [WAIT_W-1:0]  rd_wait
);
    localparam int NSP = 1 << SPACE_W;

    logic [NSP*2-1:0]      width_flat;
    logic [NSP*WAIT_W-1:0] wait_flat;

    generate
        for (genvar s = 0; s < NSP; s++) begin : g_space
            logic [1:0]        width_q;
            logic [WAIT_W-1:0] wait_q;

            // Hold this space's settings; reset to the slowest, narrowest setting.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    width_q <= 2'd0;
                    wait_q  <= '1;
                end else if (cfg_we && (cfg_sel == SPACE_W'(s))) begin
                    width_q <= cfg_width;
                    wait_q  <= cfg_wait;
                end
            end

            assign width_flat[s*2 +: 2]          = width_q;
            assign wait_flat[s*WAIT_W +: WAIT_W] = wait_q;
        end
    endgenerate

    assign rd_width = width_flat[rd_sel*2 +: 2];
    assign rd_wait  = wait_flat[rd_sel*WAIT_W +: WAIT_W];

endmodule

// File: rtl/xbus_seq.sv
`timescale 1ns/1ps
// Beat sequencer: for each beat runs setup (1), strobe (wait+1) and hold (1)
// cycles, then moves to the next beat or back to idle.
// Assumes beat count and wait count stay stable while a request is active.
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        last_beat,
    input  logic [WAIT_W-1:0] wait_cnt,
    output phase_t            phase,
    output logic [1:0]        beat,
    output logic              sample,
    output logic              finish
);
    phase_t            ph_q;
    logic [WAIT_W-1:0] wcnt_q;
    logic [1:0]        beat_q;

    // Advance the per-beat phase and the strobe and beat counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= PH_IDLE;
            wcnt_q <= '0;
            beat_q <= 2'd0;
        end else begin
            case (ph_q)
                PH_IDLE: begin
                    if (start) begin
                        ph_q   <= PH_SETUP;
                        beat_q <= 2'd0;
                    end
                end
                PH_SETUP: begin
                    ph_q   <= PH_STROBE;
                    wcnt_q <= '0;
                end
                PH_STROBE: begin
                    if (wcnt_q == wait_cnt) ph_q <= PH_HOLD;
                    else                    wcnt_q <= wcnt_q + 1'b1;
                end
                default: begin
                    if (beat_q == last_beat) begin
                        ph_q <= PH_IDLE;
                    end else begin
                        beat_q <= beat_q + 1'b1;
                        ph_q   <= PH_SETUP;
                    end
                end
            endcase
        end
    end

    assign phase  = ph_q;
    assign beat   = beat_q;
    assign sample = (ph_q == PH_STROBE) && (wcnt_q == wait_cnt);
    assign finish = (ph_q == PH_HOLD) && (beat_q == last_beat);

endmodule

// File: rtl/xbus_lane.sv
`timescale 1ns/1ps
// Lane unit: splits the write word into narrow beats on the low data lanes and
// packs sampled read beats little-endian into the 32-bit result.
// Assumes a 32-bit word and beat indices within the width's beat count.
module xbus_lane (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [31:0] wdata_in,
    input  logic [1:0]  width,
    input  logic [1:0]  beat,
    input  logic        capture,
    input  logic [31:0] dq_i,
    output logic [31:0] dq_o,
    output logic [31:0] rdata
);
    logic [31:0] wdata_q;
    logic [31:0] rdata_q;
    logic [4:0]  shamt;
    logic [31:0] mask;

    // Bit offset and lane mask of the current beat.
    always_comb begin
        case (width)
            2'd0: begin
                shamt = {beat, 3'b000};
                mask  = 32'h0000_00FF;
            end
            2'd1: begin
                shamt = {beat[0], 4'b0000};
                mask  = 32'h0000_FFFF;
            end
            default: begin
                shamt = 5'd0;
                mask  = 32'hFFFF_FFFF;
            end
        endcase
    end

    // Capture the write word at accept; merge each sampled read beat into place.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdata_q <= '0;
            rdata_q <= '0;
        end else if (load) begin
            wdata_q <= wdata_in;
            rdata_q <= '0;
        end else if (capture) begin
            rdata_q <= (rdata_q & ~(mask << shamt)) | ((dq_i & mask) << shamt);
        end
    end

    assign dq_o  = (wdata_q >> shamt) & mask;
    assign rdata = rdata_q;

endmodule

// File: rtl/xbus_ctrl.sv
`timescale 1ns/1ps
// Four-space asynchronous static bus controller (top).
// Accepts one 32-bit request when idle, latches the space's width and wait
// settings, and runs 1, 2 or 4 beats on the external bus with per-space chip
// select. Assumes the requester holds no expectation of overlap: one request at a time.
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int SPACE_W = 2,
    parameter int ADDR_W  = 22,
    parameter int WAIT_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [SPACE_W-1:0]        cfg_sel,
    input  logic [1:0]                cfg_width,
    input  logic [WAIT_W-1:0]         cfg_wait,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [SPACE_W+ADDR_W-1:0] req_addr,
    input  logic [31:0]               req_wdata,
    output logic                      busy,
    output logic                      rsp_done,
    output logic [31:0]               rsp_rdata,
    output logic [ADDR_W-1:0]         ext_addr,
    output logic [(1<<SPACE_W)-1:0]   ext_cs_n,
    output logic                      ext_we_n,
    output logic                      ext_oe_n,
    output logic [31:0]               ext_dq_o,
    output logic                      ext_dq_oe,
    input  logic [31:0]               ext_dq_i
);
    localparam int NSP = 1 << SPACE_W;

    phase_t             phase;
    logic [1:0]         beat;
    logic               sample;
    logic               finish;
    logic               accept;
    logic               active;
    logic               strobe;
    logic [1:0]         sel_width;
    logic [WAIT_W-1:0]  sel_wait;

    logic [SPACE_W-1:0] space_q;
    logic [ADDR_W-1:0]  base_q;
    logic               write_q;
    logic [1:0]         width_q;
    logic [WAIT_W-1:0]  wait_q;
    logic [1:0]         last_q;
    logic               done_q;
    logic [2:0]         beat_off;

    assign accept = req_valid && (phase == PH_IDLE);
    assign active = (phase != PH_IDLE);
    assign strobe = (phase == PH_STROBE);

    xbus_cfg_bank #(
        .SPACE_W (SPACE_W),
        .WAIT_W  (WAIT_W)
    ) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_width (cfg_width),
        .cfg_wait  (cfg_wait),
        .rd_sel    (req_addr[SPACE_W+ADDR_W-1 -: SPACE_W]),
        .rd_width  (sel_width),
        .rd_wait   (sel_wait)
    );

    // Latch the request and its space's settings at accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            space_q <= '0;
            base_q  <= '0;
            write_q <= 1'b0;
            width_q <= 2'd0;
            wait_q  <= '0;
            last_q  <= 2'd0;
        end else if (accept) begin
            space_q <= req_addr[SPACE_W+ADDR_W-1 -: SPACE_W];
            base_q  <= req_addr[ADDR_W-1:0] & ~ADDR_W'(3);
            write_q <= req_write;
            width_q <= sel_width;
            wait_q  <= sel_wait;
            last_q  <= beats_less_one(sel_width);
        end
    end

    // Register the completion pulse one cycle after the final hold cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= finish;
    end

    xbus_seq #(
        .WAIT_W (WAIT_W)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .last_beat (last_q),
        .wait_cnt  (wait_q),
        .phase     (phase),
        .beat      (beat),
        .sample    (sample),
        .finish    (finish)
    );

    xbus_lane lane_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .wdata_in (req_wdata),
        .width    (width_q),
        .beat     (beat),
        .capture  (sample && !write_q),
        .dq_i     (ext_dq_i),
        .dq_o     (ext_dq_o),
        .rdata    (rsp_rdata)
    );

    // Byte offset of the current beat from the aligned base.
    always_comb begin
        case (width_q)
            2'd0:    beat_off = {1'b0, beat};
            2'd1:    beat_off = {beat, 1'b0};
            default: beat_off = 3'd0;
        endcase
    end

    assign ext_addr = base_q + ADDR_W'(beat_off);

    generate
        for (genvar s = 0; s < NSP; s++) begin : g_cs
            assign ext_cs_n[s] = !(active && (space_q == SPACE_W'(s)));
        end
    endgenerate

    assign ext_we_n  = !(strobe && write_q);
    assign ext_oe_n  = !(strobe && !write_q);
    assign ext_dq_oe = strobe && write_q;
    assign busy      = active;
    assign rsp_done  = done_q;

endmodule

// File: rtl/xbus_ctrl_chk.sv
`timescale 1ns/1ps
// Bus-protocol checker for xbus_ctrl, attached with bind.
// Assumes synchronous active-low reset; all properties are disabled in reset.
module xbus_ctrl_chk #(
    parameter int NSP    = 4,
    parameter int WAIT_W = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_valid,
    input logic           busy,
    input logic           rsp_done,
    input logic [NSP-1:0] ext_cs_n,
    input logic           ext_we_n,
    input logic           ext_oe_n,
    input logic           ext_dq_oe
);
    logic          stb;
    logic [WAIT_W:0] run_q;

    assign stb = !ext_we_n || !ext_oe_n;

    // Count consecutive strobe cycles to bound the strobe length.
    always_ff @(posedge clk) begin
        if (!rst_n)   run_q <= '0;
        else if (stb) run_q <= run_q + 1'b1;
        else          run_q <= '0;
    end

    // R1: at most one space selected
    a_r1_one_space: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ext_cs_n));

    // R1: chip select constant across a request
    a_r1_cs_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(ext_cs_n));

    // R4: chip select already low before a strobe falls
    a_r4_setup_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stb) |-> (($past(ext_cs_n) == ext_cs_n) && (ext_cs_n != '1)));

    // R4: chip select still low after a strobe rises
    a_r4_hold_after: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stb) |-> (ext_cs_n != '1));

    // R3: strobe never longer than the largest wait count allows
    a_r3_strobe_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= (WAIT_W+1)'(1 << WAIT_W));

    // R6: strobes exclusive and data driven only under the write strobe
    a_r6_strobes_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ext_we_n && !ext_oe_n));
    a_r6_drive_window: assert property (@(posedge clk) disable iff (!rst_n)
        ext_dq_oe == !ext_we_n);

    // R8: an accepted request raises busy
    a_r8_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    // R7: one-cycle done pulse, right after the bus is released
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    a_r7_done_release: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (($past(ext_cs_n) != '1) && (ext_cs_n == '1)));

endmodule

bind xbus_ctrl xbus_ctrl_chk #(
    .NSP    (1 << SPACE_W),
    .WAIT_W (WAIT_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .rsp_done  (rsp_done),
    .ext_cs_n  (ext_cs_n),
    .ext_we_n  (ext_we_n),
    .ext_oe_n  (ext_oe_n),
    .ext_dq_oe (ext_dq_oe)
);

// File: tb/xbus_ctrl_tb_top.sv
`timescale 1ns/1ps
// Sweep bench: every space x width code x several wait counts, against a byte memory model.
module xbus_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [1:0]  cfg_sel;
    logic [1:0]  cfg_width;
    logic [3:0]  cfg_wait;
    logic        req_valid;
    logic        req_write;
    logic [23:0] req_addr;
    logic [31:0] req_wdata;
    logic        busy;
    logic        rsp_done;
    logic [31:0] rsp_rdata;
    logic [21:0] ext_addr;
    logic [3:0]  ext_cs_n;
    logic        ext_we_n;
    logic        ext_oe_n;
    logic [31:0] ext_dq_o;
    logic        ext_dq_oe;
    logic [31:0] ext_dq_i;

    always #2 clk = ~clk;

    xbus_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_width(cfg_width), .cfg_wait(cfg_wait),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .ext_addr(ext_addr), .ext_cs_n(ext_cs_n), .ext_we_n(ext_we_n), .ext_oe_n(ext_oe_n),
        .ext_dq_o(ext_dq_o), .ext_dq_oe(ext_dq_oe), .ext_dq_i(ext_dq_i)
    );

    logic [7:0] mem [4][256];
    int         bw_model [4];
    int         checks = 0;
    int         errors = 0;

    // Read model: memory bytes little-endian on the data lanes under output enable.
    always_comb begin
        logic [7:0] a;
        a = ext_addr[7:0];
        ext_dq_i = 32'hA5A5_A5A5;
        if (!ext_oe_n) begin
            for (int s = 0; s < 4; s++) begin
                if (!ext_cs_n[s])
                    ext_dq_i = {mem[s][a+8'd3], mem[s][a+8'd2], mem[s][a+8'd1], mem[s][a]};
            end
        end
    end

    // Write model: store the low lanes of the selected space's width under write enable.
    always @(posedge clk) begin
        if (!ext_we_n) begin
            for (int s = 0; s < 4; s++) begin
                if (!ext_cs_n[s]) begin
                    for (int b = 0; b < bw_model[s]; b++)
                        mem[s][ext_addr[7:0] + 8'(b)] = ext_dq_o[8*b +: 8];
                end
            end
        end
    end

    // Beat monitor state.
    logic [21:0] exp_base;
    int          exp_step, exp_wait;
    logic [3:0]  exp_cs;
    int          beat_cnt, stb_len, bad_len, bad_addr, bad_cs, bad_oe, bad_lane;
    logic        prev_stb = 1'b0;

    // Sample the bus away from the clock edge and record beat timing and addresses.
    always @(negedge clk) begin
        logic stb;
        stb = !ext_we_n || !ext_oe_n;
        if (stb) begin
            if (!prev_stb) begin
                if (ext_addr != exp_base + 22'(exp_step * beat_cnt)) bad_addr++;
                stb_len = 1;
            end else begin
                stb_len++;
            end
            if (!ext_we_n && exp_step < 4 && (ext_dq_o >> (8*exp_step)) != 32'd0) bad_lane++;
        end else if (prev_stb) begin
            if (stb_len != exp_wait + 1) bad_len++;
            beat_cnt++;
        end
        if (ext_cs_n != 4'hF && ext_cs_n != exp_cs) bad_cs++;
        if (ext_dq_oe != !ext_we_n) bad_oe++;
        prev_stb = stb;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(input int sp, input int wc, input int wt);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'(sp); cfg_width = 2'(wc); cfg_wait = 4'(wt);
        @(negedge clk);
        cfg_we = 1'b0;
        bw_model[sp] = (wc == 0) ? 1 : (wc == 1) ? 2 : 4;
    endtask

    // One access; junk != 0 keeps a second request on another space asserted while busy.
    task automatic run(input int sp, input bit wr, input logic [21:0] off, input logic [31:0] wd,
                       input int wc, input int wt, input bit junk, output logic [31:0] rd);
        int bpb, nb, lat, cnt;
        bpb = (wc == 0) ? 1 : (wc == 1) ? 2 : 4;
        nb  = 4 / bpb;
        lat = nb * (wt + 3);
        exp_base = {off[21:2], 2'b00};
        exp_step = bpb; exp_wait = wt;
        exp_cs   = ~(4'b0001 << sp);
        beat_cnt = 0; bad_len = 0; bad_addr = 0; bad_cs = 0; bad_oe = 0; bad_lane = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = {2'(sp), off}; req_wdata = wd;
        @(negedge clk);
        if (junk) begin
            req_addr  = {2'(sp + 1), off ^ 22'h000040};
            req_write = 1'b1;
            req_wdata = 32'hDEAD_BEEF;
        end else begin
            req_valid = 1'b0;
        end
        cnt = 1;
        while (!rsp_done && cnt < 2000) begin
            @(negedge clk);
            cnt++;
        end
        req_valid = 1'b0;
        rd = rsp_rdata;
        chk(cnt == lat + 1, "R7", "latency", cnt, lat + 1);
        chk(beat_cnt == nb, "R2", "beat count", beat_cnt, nb);
        chk(bad_addr == 0, "R2", "beat addresses", bad_addr, 0);
        chk(bad_len == 0, "R3", "strobe length", bad_len, 0);
        chk(bad_cs == 0, "R1", "chip select", bad_cs, 0);
        chk(ext_cs_n == 4'hF, "R4", "release after hold", ext_cs_n, 4'hF);
        chk(bad_oe == 0, "R6", "drive window", bad_oe, 0);
        chk(bad_lane == 0, "R6", "unused lanes", bad_lane, 0);
        @(negedge clk);
        chk(!rsp_done && !busy, "R7", "single pulse, idle", {rsp_done, busy}, 0);
    endtask

    function automatic logic [31:0] model_word(input int sp, input logic [7:0] a);
        return {mem[sp][a+8'd3], mem[sp][a+8'd2], mem[sp][a+8'd1], mem[sp][a]};
    endfunction

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd, exp_rd, wd;
        logic [21:0] off;
        logic [7:0]  a;
        int          waits [3] = '{0, 2, 5};
        for (int s = 0; s < 4; s++) begin
            bw_model[s] = 1;
            for (int i = 0; i < 256; i++) mem[s][i] = 8'(s * 64 + i) ^ 8'h5A;
        end
        exp_base = '0; exp_step = 1; exp_wait = 0; exp_cs = 4'hF;
        rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_width = '0; cfg_wait = '0;
        req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        // R9: idle outputs during reset, even with a request presented
        req_valid = 1'b1;
        @(negedge clk);
        chk(ext_cs_n == 4'hF && ext_we_n && ext_oe_n, "R9", "bus idle in reset",
            {ext_cs_n, ext_we_n, ext_oe_n}, 6'h3F);
        chk(!ext_dq_oe && !busy && !rsp_done, "R9", "status low in reset",
            {ext_dq_oe, busy, rsp_done}, 0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        // R9: default configuration is 8-bit, 15 waits
        off = 22'h2A_5C31;
        run(2, 1'b0, off, 32'd0, 0, 15, 1'b0, rd);
        exp_rd = model_word(2, 8'h30);
        chk(rd == exp_rd, "R9", "default read data", rd, exp_rd);

        // Sweep every space, width code and wait count.
        for (int sp = 0; sp < 4; sp++) begin
            for (int wc = 0; wc < 3; wc++) begin
                for (int wi = 0; wi < 3; wi++) begin
                    set_cfg(sp, wc, waits[wi]);
                    a   = 8'((sp * 64 + wc * 20 + wi * 8) & 8'hFC);
                    off = {14'(sp * 911 + wc * 37 + wi), a | 8'(wi)};
                    // R5: read assembled little-endian from the model
                    exp_rd = model_word(sp, a);
                    run(sp, 1'b0, off, 32'd0, wc, waits[wi], 1'b0, rd);
                    chk(rd == exp_rd, "R5", "read assembly", rd, exp_rd);
                    // R6: write split into lanes, bytes land little-endian
                    wd = 32'h1F2E_3D4C ^ {8'(sp), 8'(wc), 8'(wi), 8'hC3};
                    run(sp, 1'b1, off, wd, wc, waits[wi], 1'b0, rd);
                    chk(model_word(sp, a) == wd, "R6", "written bytes", model_word(sp, a), wd);
                    // R7: read back the written word
                    run(sp, 1'b0, off, 32'd0, wc, waits[wi], 1'b0, rd);
                    chk(rd == wd, "R7", "read-back data", rd, wd);
                end
            end
        end

        // R8: request held while busy is ignored (memory of the other space untouched)
        set_cfg(1, 0, 1);
        set_cfg(2, 2, 0);
        a = 8'h80;
        exp_rd = model_word(2, a ^ 8'h40);
        run(1, 1'b1, {14'h0011, a}, 32'hCAFE_F00D, 0, 1, 1'b1, rd);
        chk(model_word(2, a ^ 8'h40) == exp_rd, "R8", "held request ignored",
            model_word(2, a ^ 8'h40), exp_rd);
        chk(model_word(1, a) == 32'hCAFE_F00D, "R8", "first request completed",
            model_word(1, a), 32'hCAFE_F00D);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule